// File: doc/BRIEF.md
# Multicore Inter-Processor Interrupt Controller

This block lets any core of a multicore system raise an interrupt on any other core, through a small memory-mapped register file on a simple single-cycle bus. Each core owns two 32-bit words: a command word and a status word. Writing the command word with the generate bit set, a destination core number and a 16-bit payload makes the destination's interrupt line rise. Writing the acknowledge bit lowers it again. The destination reads its status word to learn which core sent the interrupt and what payload came with it.

Each core has one interrupt output. The line is driven straight from that core's pending flag. The number of cores is a parameter, and it sets the width of the byte address. Accesses are always full 32-bit words. A lane-order parameter lets the block sit on a bus that presents bytes in the other order. At the default setting, bit 31 of the bus word is the most significant bit of each register. Ordering, vectoring and any tracking of software work items are left to software.

Top module: `xirq_ctrl`

## Requirements
- R1: Addresses are byte addresses. Core k's command word is at k*8 and its status word is at k*8+4. Address bits 1:0 are ignored. A word whose core index is at or above NUM_CORES reads as zero, and writing it has no effect.
- R2: A write to a command word with bit 30 (generate) set and bits 29:16 holding a destination d < NUM_CORES sets core d's pending flag. irq_o[d] is high from the first clock edge after the write cycle.
- R3: A write to core k's command word with bit 31 (acknowledge) set and no generate aimed at k clears core k's pending flag. irq_o[k] is low from the first clock edge after the write.
- R4: A status read returns 0 in bit 31, the pending flag in bit 30, the sending core's number in bits 29:16 and the payload in bits 15:0. bus_rdata holds this value from the clock edge that samples the read until the next read.
- R5: irq_o[k] changes only through a generate aimed at k or an acknowledge written to k's command word. Reads and writes that concern other cores leave it unchanged.
- R6: A generate whose destination is NUM_CORES or above changes no pending flag, no source and no payload.
- R7: When one write both acknowledges core k and generates to core k, the generate wins and core k stays pending.
- R8: A generate aimed at a core that is already pending replaces that core's recorded source and payload with the new ones.
- R9: A write to core j's command word acts as core j's own write, whoever issues it. Its acknowledge clears core j, and its generate records j as the source.
- R10: After reset every irq_o line is low and every status word reads as zero.
- R11: Command words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, ADDR_W = index width + 3 |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, registered |
| irq_o | output | NUM_CORES | One interrupt line per core |

## Verification
A write is sampled at one clock edge, and the pending flags and interrupt lines change at that same edge. The bench therefore compares irq_o against its model at the falling edge that follows the write. A read is also sampled at one edge, and bus_rdata is registered there. The driver queues the expected word when it issues the read, computing it from the model state at that moment. The monitor notes each edge that sampled a read and pops and compares the queued word at the next falling edge, so every result is checked half a cycle after it appears.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned DEST_W   = 14;
   localparam int unsigned PAY_W    = 16;
   localparam int unsigned MAX_CORE = 1 << DEST_W;

   // command word as written by a core
   typedef struct packed {
      logic              ack;
      logic              gen;
      logic [DEST_W-1:0] dest;
      logic [PAY_W-1:0]  pay;
   } cmd_t;

   // status word as read by a core
   typedef struct packed {
      logic              zero;
      logic              pend;
      logic [DEST_W-1:0] src;
      logic [PAY_W-1:0]  pay;
   } stat_t;

   function automatic int unsigned idx_width(int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/xirq_decode.sv
module xirq_decode
   import xirq_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned IDX_W     = 2
) (
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [IDX_W:0]       word_addr,
   input  logic [WORD_W-1:0]    wr_word,
   output logic [NUM_CORES-1:0] gen_vec,
   output logic [NUM_CORES-1:0] ack_vec,
   output logic [DEST_W-1:0]    gen_src,
   output logic [PAY_W-1:0]     gen_pay,
   output logic                 rd_en,
   output logic                 rd_hit,
   output logic                 rd_stat,
   output logic [IDX_W-1:0]     rd_idx
);
   cmd_t             cmd;
   logic [IDX_W-1:0] idx;
   logic             idx_ok;
   logic             cmd_wr;
   logic             dest_ok;

   assign cmd     = cmd_t'(wr_word);
   assign idx     = word_addr[IDX_W:1];
   assign idx_ok  = 32'(idx) < NUM_CORES;
   assign cmd_wr  = bus_sel && bus_we && idx_ok && !word_addr[0];
   assign dest_ok = 32'(cmd.dest) < NUM_CORES;

   assign gen_src = DEST_W'(idx);
   assign gen_pay = cmd.pay;

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_strobe
      assign ack_vec[i] = cmd_wr && cmd.ack && (idx == IDX_W'(i));
      assign gen_vec[i] = cmd_wr && cmd.gen && dest_ok && (cmd.dest == DEST_W'(i));
   end

   assign rd_en   = bus_sel && !bus_we;
   assign rd_hit  = idx_ok;
   assign rd_stat = word_addr[0];
   assign rd_idx  = idx;
endmodule

// File: rtl/xirq_slot.sv
module xirq_slot
   import xirq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gen_i,
   input  logic              ack_i,
   input  logic [DEST_W-1:0] src_i,
   input  logic [PAY_W-1:0]  pay_i,
   output logic              pend_o,
   output logic [DEST_W-1:0] src_o,
   output logic [PAY_W-1:0]  pay_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= 1'b0;
         src_o  <= '0;
         pay_o  <= '0;
      end else if (gen_i) begin
         pend_o <= 1'b1;
         src_o  <= src_i;
         pay_o  <= pay_i;
      end else if (ack_i) begin
         pend_o <= 1'b0;
      end
   end
endmodule

// File: rtl/xirq_rd_mux.sv
module xirq_rd_mux
   import xirq_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned IDX_W     = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               rd_en,
   input  logic                               rd_hit,
   input  logic                               rd_stat,
   input  logic [IDX_W-1:0]                   rd_idx,
   input  logic [NUM_CORES-1:0]               pend_vec,
   input  logic [NUM_CORES-1:0][DEST_W-1:0]   src_arr,
   input  logic [NUM_CORES-1:0][PAY_W-1:0]    pay_arr,
   output logic [WORD_W-1:0]                  rd_word
);
   stat_t pick;

   always_comb begin
      pick = '0;
      for (int i = 0; i < NUM_CORES; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            pick.pend = pend_vec[i];
            pick.src  = src_arr[i];
            pick.pay  = pay_arr[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_word <= '0;
      end else if (rd_en) begin
         rd_word <= (rd_hit && rd_stat) ? WORD_W'(pick) : '0;
      end
   end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
   import xirq_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter bit          LANE_SWAP = 1'b0,
   localparam int unsigned IDX_W    = idx_width(NUM_CORES),
   localparam int unsigned ADDR_W   = IDX_W + 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic [NUM_CORES-1:0] irq_o
);
   if (NUM_CORES < 1 || NUM_CORES > MAX_CORE) begin : g_bad_cores
      $error("xirq_ctrl: NUM_CORES out of range");
   end
   if (WORD_W != 32 || DEST_W + PAY_W + 2 != WORD_W) begin : g_bad_word
      $error("xirq_ctrl: command word layout does not fill 32 bits");
   end

   logic [WORD_W-1:0]                wr_word;
   logic [WORD_W-1:0]                rd_word;
   logic [NUM_CORES-1:0]             gen_vec;
   logic [NUM_CORES-1:0]             ack_vec;
   logic [DEST_W-1:0]                gen_src;
   logic [PAY_W-1:0]                 gen_pay;
   logic                             rd_en;
   logic                             rd_hit;
   logic                             rd_stat;
   logic [IDX_W-1:0]                 rd_idx;
   logic [NUM_CORES-1:0]             pend_vec;
   logic [NUM_CORES-1:0][DEST_W-1:0] src_arr;
   logic [NUM_CORES-1:0][PAY_W-1:0]  pay_arr;
   logic                             unused_lsb;

   assign unused_lsb = ^bus_addr[1:0];

   if (LANE_SWAP) begin : g_swap
      assign wr_word   = {bus_wdata[7:0], bus_wdata[15:8], bus_wdata[23:16], bus_wdata[31:24]};
      assign bus_rdata = {rd_word[7:0], rd_word[15:8], rd_word[23:16], rd_word[31:24]};
   end else begin : g_pass
      assign wr_word   = bus_wdata;
      assign bus_rdata = rd_word;
   end

   xirq_decode #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_dec (
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .word_addr (bus_addr[ADDR_W-1:2]),
      .wr_word   (wr_word),
      .gen_vec   (gen_vec),
      .ack_vec   (ack_vec),
      .gen_src   (gen_src),
      .gen_pay   (gen_pay),
      .rd_en     (rd_en),
      .rd_hit    (rd_hit),
      .rd_stat   (rd_stat),
      .rd_idx    (rd_idx)
   );

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
      xirq_slot u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .gen_i  (gen_vec[i]),
         .ack_i  (ack_vec[i]),
         .src_i  (gen_src),
         .pay_i  (gen_pay),
         .pend_o (pend_vec[i]),
         .src_o  (src_arr[i]),
         .pay_o  (pay_arr[i])
      );
   end

   xirq_rd_mux #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_hit   (rd_hit),
      .rd_stat  (rd_stat),
      .rd_idx   (rd_idx),
      .pend_vec (pend_vec),
      .src_arr  (src_arr),
      .pay_arr  (pay_arr),
      .rd_word  (rd_word)
   );

   assign irq_o = pend_vec;
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk
   import xirq_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   localparam int unsigned IDX_W    = idx_width(NUM_CORES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_sel,
   input logic                 bus_we,
   input logic [IDX_W:0]       word_addr,
   input logic [15:0]          wr_hi,
   input logic [1:0]           rd_top,
   input logic [NUM_CORES-1:0] irq_o,
   input logic [NUM_CORES-1:0] gen_vec,
   input logic [NUM_CORES-1:0] ack_vec
);
   logic cmd_wr;
   assign cmd_wr = bus_sel && bus_we && !word_addr[0];

   p_reset_r10: assert property (@(posedge clk) $rose(rst_n) |-> (irq_o == '0));

   p_gen_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gen_vec));

   p_ack_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_vec));

   // R6: destination outside the core range produces no strobe
   p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wr_hi[14] && (32'(wr_hi[13:0]) >= NUM_CORES)) |-> (gen_vec == '0));

   p_stat_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_top[1]);

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
      p_gen_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
         gen_vec[i] |=> irq_o[i]);

      // R3 / R9: acknowledge on core i's command word, no generate at all
      p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_wr && wr_hi[15] && !wr_hi[14] && (word_addr[IDX_W:1] == IDX_W'(i)))
         |=> !irq_o[i]);

      p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!gen_vec[i] && !ack_vec[i]) |=> $stable(irq_o[i]));

      p_stat_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && !bus_we && word_addr[0] && (word_addr[IDX_W:1] == IDX_W'(i)))
         |=> (rd_top[0] == $past(irq_o[i])));
   end
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.NUM_CORES(NUM_CORES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .word_addr (bus_addr[ADDR_W-1:2]),
   .wr_hi     (wr_word[31:16]),
   .rd_top    (rd_word[31:30]),
   .irq_o     (irq_o),
   .gen_vec   (gen_vec),
   .ack_vec   (ack_vec)
);

// File: tb/xirq_ctrl_tb.sv
`timescale 1ns/1ps
module xirq_ctrl_tb;
   localparam int N  = 3;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  irq_o;

   int tests = 0;
   int fails = 0;

   // reference model
   logic [N-1:0] m_pend = '0;
   logic [13:0]  m_src [N];
   logic [15:0]  m_pay [N];

   logic [31:0] exp_q [$];
   string       req_q [$];
   logic        rd_seen = 1'b0;

   always #4 clk = ~clk;

   xirq_ctrl #(.NUM_CORES(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [AW-1:0] a);
      int k = int'(a[4:3]);
      if (k >= N || !a[2]) return 32'h0;
      return {1'b0, m_pend[k], m_src[k], m_pay[k]};
   endfunction

   function automatic void model_write(input logic [AW-1:0] a, input logic [31:0] d);
      int k = int'(a[4:3]);
      int t = int'(d[29:16]);
      if (k >= N || a[2]) return;
      if (d[31]) m_pend[k] = 1'b0;
      if (d[30] && t < N) begin
         m_pend[t] = 1'b1;
         m_src[t]  = 14'(k);
         m_pay[t]  = d[15:0];
      end
   endfunction

   // driver: called right after a falling edge
   task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, input string req);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      model_write(a, d);
      check({req, " irq"}, 32'(irq_o), 32'(m_pend));
   endtask

   task automatic bus_read(input logic [AW-1:0] a, input string req);
      exp_q.push_back(model_read(a));
      req_q.push_back(req);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   // monitor
   always @(posedge clk) rd_seen <= bus_sel && !bus_we;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            tests++; fails++;
            $display("FAIL R4: read result with no expected entry, actual %h expected none", bus_rdata);
         end else begin
            check(req_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic summary;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      summary();
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_src[i] = '0; m_pay[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 irq after reset", 32'(irq_o), 32'h0);
      for (int i = 0; i < N; i++) bus_read(AW'(i*8 + 4), "R10 status after reset");

      // R2: core 0 raises core 2
      bus_write(5'd0, 32'h4002_BEEF, "R2");
      check("R2 irq line 2", 32'(irq_o[2]), 32'h1);
      bus_read(5'd20, "R4 status of core 2");
      check("R4 expected word", model_read(5'd20), 32'h4000_BEEF);

      // R2: core 1 raises core 0
      bus_write(5'd8, 32'h4000_1234, "R2");
      bus_read(5'd4, "R4 status of core 0");

      // R11: command words read zero
      bus_read(5'd8, "R11 command read");
      bus_read(5'd0, "R11 command read");

      // R6: destinations out of range
      bus_write(5'd0, 32'h4003_AAAA, "R6 dest 3");
      bus_write(5'd0, 32'h7FFF_AAAA, "R6 dest max");
      bus_read(5'd20, "R6 status unchanged");
      bus_read(5'd4, "R6 status unchanged");

      // R3: core 2 acknowledges
      bus_write(5'd16, 32'h8000_0000, "R3");
      check("R3 irq line 2 low", 32'(irq_o[2]), 32'h0);
      bus_read(5'd20, "R3 status after ack");

      // R8: overwrite pending core 0
      bus_write(5'd16, 32'h4000_5555, "R8");
      bus_read(5'd4, "R8 new source and payload");

      // R7: ack and generate to self in one write
      bus_write(5'd8, 32'hC001_7777, "R7");
      check("R7 irq line 1 high", 32'(irq_o[1]), 32'h1);
      bus_read(5'd12, "R7 status of core 1");

      // R9: any master writes core 1's command word
      bus_write(5'd8, 32'h8000_0000, "R9 ack via core 1 word");
      check("R9 irq line 1 low", 32'(irq_o[1]), 32'h0);
      bus_write(5'd16, 32'h4001_0042, "R9 gen via core 2 word");
      bus_read(5'd12, "R9 source recorded as 2");

      // R1: unmapped core index 3, ignored low address bits
      bus_write(5'd24, 32'h4000_9999, "R1 unmapped write");
      bus_read(5'd24, "R1 unmapped command");
      bus_read(5'd28, "R1 unmapped status");
      bus_read(5'd4, "R1 core 0 untouched");
      bus_read(5'd15, "R1 low bits ignored");
      bus_write(5'd19, 32'h8000_0000, "R1 low bits ignored, ack core 2");

      // R5: reads leave lines alone
      bus_read(5'd4, "R5 read");
      bus_read(5'd12, "R5 read");
      check("R5 irq stable", 32'(irq_o), 32'(m_pend));

      // R4: bus_rdata holds between reads
      repeat (3) @(negedge clk);
      check("R4 read data held", bus_rdata, model_read(5'd12));

      repeat (2) @(negedge clk);
      check("R4 queue drained", 32'(exp_q.size()), 32'h0);
      summary();
   end
endmodule